// File: doc/BRIEF.md
# Coherent Request Forwarding Filter

This block sits between the request pipeline of a cache coherency controller and a downstream last-level cache. Each incoming request carries an opcode, and the block chooses one of three destinations for it. Normal reads and writes go to the forward port. Cache maintenance operations (flush or invalidate) go to the forward port, or they are stopped and completed locally. Clean write-evict requests go to the forward port with their data, or the data is dropped and a release of the requesting master's copy is sent on the directory port.

Two enable bits in a 64-bit control register steer these choices. The register is reached through a single-cycle register bus. Only an access that is both secure and privileged may read or write it. Any other access is refused with an error.

The request, forward and directory ports all use valid/ready. A request is taken only when its chosen destination can take it. Each output port has a one-entry register stage, and that stage keeps full throughput while its consumer is ready. While `fwd_ready` or `dir_ready` is low and that stage is full, requests bound for it see `req_ready` low. Requests routed elsewhere still flow. Request order is preserved on each port.

Top module: `coh_fwd_filter`

## Requirements
- R1: After reset the control register reads 0. Bit 1 is the maintenance enable and bit 0 is the write-evict enable. Bits 63:2 always read 0, and a write to them has no effect.
- R2: An access with `reg_valid` high gets a response one cycle later (`reg_resp_valid`). An access that is not both secure and privileged returns `reg_err`=1 with read data 0 and leaves the register unchanged. An allowed access returns `reg_err`=0, and an allowed read returns the register value.
- R3: Opcodes 2 (flush) and 3 (invalidate) are maintenance operations. When bit 1 is 1, each one appears on the forward port in the cycle after acceptance, with its opcode, address, data and source unchanged.
- R4: When bit 1 is 0, a maintenance operation is accepted whatever the forward port's state and is never forwarded. `cmo_done` pulses for one cycle in the cycle after acceptance, with `cmo_done_src` equal to the request's source.
- R5: Opcode 4 is write-evict. When bit 0 is 1, it appears on the forward port with its data in the cycle after acceptance.
- R6: When bit 0 is 0, a write-evict is not forwarded. In the cycle after acceptance a directory release appears on the directory port, carrying the request's address and source.
- R7: Opcodes 0 (read), 1 (write) and 5 to 7 are normal requests. They are forwarded for every setting of the enable bits.
- R8: While an output port's valid is high and its ready is low, its valid and payload hold steady. Suppose a request is bound for that port while the port's stage is full and not draining: then `req_ready` is low.
- R9: A register write that completes at a clock edge steers requests accepted from the next cycle on. A request accepted at that same edge uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_secure | input | 1 | Access is secure |
| reg_priv | input | 1 | Access is privileged |
| reg_wdata | input | 64 | Write data |
| reg_resp_valid | output | 1 | Response strobe, one cycle after access |
| reg_rdata | output | 64 | Read data |
| reg_err | output | 1 | Access refused |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 3 | Request opcode |
| req_addr | input | 32 | Line address |
| req_data | input | 64 | Request data |
| req_src | input | 4 | Requesting master |
| fwd_valid | output | 1 | Forward port valid |
| fwd_ready | input | 1 | Forward port ready |
| fwd_op | output | 3 | Forwarded opcode |
| fwd_addr | output | 32 | Forwarded address |
| fwd_data | output | 64 | Forwarded data |
| fwd_src | output | 4 | Forwarded source |
| dir_valid | output | 1 | Directory release valid |
| dir_ready | input | 1 | Directory port ready |
| dir_addr | output | 32 | Released line address |
| dir_src | output | 4 | Master giving up the line |
| cmo_done | output | 1 | Local completion of a stopped maintenance operation |
| cmo_done_src | output | 4 | Source of the completed operation |

## Verification
The properties rely on the inputs being known whenever they matter. `req_op` must be defined while `req_valid` is high. The access attributes must be defined while `reg_valid` is high. The hold checks on the output ports assume that a consumer only lowers ready, and never forces the stage to drop data. The stimulus changes every input half a cycle away from the sampling edge. It keeps each request steady until the cycle it is accepted, and it drives opcodes and access attributes only from fixed table entries or named constants.

// File: rtl/cff_pkg.sv
package cff_pkg;
  localparam logic [2:0] OP_RD      = 3'd0;
  localparam logic [2:0] OP_WR      = 3'd1;
  localparam logic [2:0] OP_FLUSH   = 3'd2;
  localparam logic [2:0] OP_INVAL   = 3'd3;
  localparam logic [2:0] OP_WEVICT  = 3'd4;

  localparam int CM_BIT = 1;
  localparam int WE_BIT = 0;

  typedef enum logic [1:0] {
    DST_FWD  = 2'd0,
    DST_DIR  = 2'd1,
    DST_DONE = 2'd2
  } dest_e;

  function automatic logic is_maint(input logic [2:0] op);
    return (op == OP_FLUSH) || (op == OP_INVAL);
  endfunction
endpackage

// File: rtl/cff_ctrl_reg.sv
module cff_ctrl_reg #(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic             reg_secure,
  input  logic             reg_priv,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             reg_resp_valid,
  output logic [REG_W-1:0] reg_rdata,
  output logic             reg_err,
  output logic             cm_en,
  output logic             we_en
);
  import cff_pkg::*;

  logic allowed;
  wire  unused_rsvd = ^reg_wdata[REG_W-1:2];

  assign allowed = reg_secure && reg_priv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cm_en          <= 1'b0;
      we_en          <= 1'b0;
      reg_resp_valid <= 1'b0;
      reg_rdata      <= '0;
      reg_err        <= 1'b0;
    end else begin
      reg_resp_valid <= reg_valid;
      reg_err        <= reg_valid && !allowed;
      reg_rdata      <= '0;
      if (reg_valid && allowed) begin
        if (reg_write) begin
          cm_en <= reg_wdata[CM_BIT];
          we_en <= reg_wdata[WE_BIT];
        end else begin
          reg_rdata[CM_BIT] <= cm_en;
          reg_rdata[WE_BIT] <= we_en;
        end
      end
    end
  end
endmodule

// File: rtl/cff_stage.sv
module cff_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/cff_router.sv
module cff_router #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [SW-1:0] req_src,
  input  logic          cm_en,
  input  logic          we_en,
  output logic          fwd_push,
  input  logic          fwd_room,
  output logic          dir_push,
  input  logic          dir_room,
  output logic          cmo_done,
  output logic [SW-1:0] cmo_done_src
);
  import cff_pkg::*;

  dest_e dest;

  always_comb begin
    dest = DST_FWD;
    if (is_maint(req_op) && !cm_en)         dest = DST_DONE;
    else if (req_op == OP_WEVICT && !we_en) dest = DST_DIR;
  end

  always_comb begin
    case (dest)
      DST_DIR:  req_ready = dir_room;
      DST_DONE: req_ready = 1'b1;
      default:  req_ready = fwd_room;
    endcase
  end

  assign fwd_push = req_valid && (dest == DST_FWD);
  assign dir_push = req_valid && (dest == DST_DIR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmo_done     <= 1'b0;
      cmo_done_src <= '0;
    end else begin
      cmo_done <= req_valid && (dest == DST_DONE);
      if (req_valid && (dest == DST_DONE)) cmo_done_src <= req_src;
    end
  end
endmodule

// File: rtl/coh_fwd_filter.sv
module coh_fwd_filter #(
  parameter int REG_W = 64,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int SW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic             reg_secure,
  input  logic             reg_priv,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             reg_resp_valid,
  output logic [REG_W-1:0] reg_rdata,
  output logic             reg_err,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  input  logic [SW-1:0]    req_src,
  output logic             fwd_valid,
  input  logic             fwd_ready,
  output logic [2:0]       fwd_op,
  output logic [AW-1:0]    fwd_addr,
  output logic [DW-1:0]    fwd_data,
  output logic [SW-1:0]    fwd_src,
  output logic             dir_valid,
  input  logic             dir_ready,
  output logic [AW-1:0]    dir_addr,
  output logic [SW-1:0]    dir_src,
  output logic             cmo_done,
  output logic [SW-1:0]    cmo_done_src
);
  localparam int FWD_W = 3 + AW + DW + SW;
  localparam int DIR_W = AW + SW;

  logic cm_en, we_en;
  logic fwd_push, fwd_room, dir_push, dir_room;

  cff_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_secure(reg_secure), .reg_priv(reg_priv),
    .reg_wdata(reg_wdata), .reg_resp_valid(reg_resp_valid),
    .reg_rdata(reg_rdata), .reg_err(reg_err),
    .cm_en(cm_en), .we_en(we_en)
  );

  cff_router #(.SW(SW)) u_route (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src(req_src),
    .cm_en(cm_en), .we_en(we_en),
    .fwd_push(fwd_push), .fwd_room(fwd_room),
    .dir_push(dir_push), .dir_room(dir_room),
    .cmo_done(cmo_done), .cmo_done_src(cmo_done_src)
  );

  cff_stage #(.W(FWD_W)) u_fwd (
    .clk(clk), .rst_n(rst_n),
    .in_valid(fwd_push), .in_ready(fwd_room),
    .in_data({req_op, req_addr, req_data, req_src}),
    .out_valid(fwd_valid), .out_ready(fwd_ready),
    .out_data({fwd_op, fwd_addr, fwd_data, fwd_src})
  );

  cff_stage #(.W(DIR_W)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dir_push), .in_ready(dir_room),
    .in_data({req_addr, req_src}),
    .out_valid(dir_valid), .out_ready(dir_ready),
    .out_data({dir_addr, dir_src})
  );
endmodule

// File: rtl/cff_checker.sv
module cff_checker #(
  parameter int REG_W = 64,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_valid,
  input logic             reg_secure,
  input logic             reg_priv,
  input logic             reg_resp_valid,
  input logic [REG_W-1:0] reg_rdata,
  input logic             reg_err,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_op,
  input logic             cm_en,
  input logic             we_en,
  input logic             fwd_valid,
  input logic             fwd_ready,
  input logic [2:0]       fwd_op,
  input logic [AW-1:0]    fwd_addr,
  input logic             dir_valid,
  input logic             dir_ready,
  input logic [AW-1:0]    dir_addr,
  input logic             cmo_done
);
  import cff_pkg::*;

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_resp_valid |-> (reg_rdata[REG_W-1:2] == '0));

  p_reject_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !(reg_secure && reg_priv)) |=>
      (reg_resp_valid && reg_err && (reg_rdata == '0)));

  p_reject_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !(reg_secure && reg_priv)) |=> $stable({cm_en, we_en}));

  p_stop_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_maint(req_op) && !cm_en) |-> req_ready);

  p_stop_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && is_maint(req_op) && !cm_en) |=> cmo_done);

  p_evict_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_op == OP_WEVICT) && !we_en) |=> dir_valid);

  p_fwd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=>
      (fwd_valid && $stable(fwd_op) && $stable(fwd_addr)));

  p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && !dir_ready) |=> (dir_valid && $stable(dir_addr)));
endmodule

bind coh_fwd_filter cff_checker #(.REG_W(REG_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .reg_valid(reg_valid), .reg_secure(reg_secure), .reg_priv(reg_priv),
  .reg_resp_valid(reg_resp_valid), .reg_rdata(reg_rdata), .reg_err(reg_err),
  .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .cm_en(cm_en), .we_en(we_en),
  .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_op(fwd_op), .fwd_addr(fwd_addr),
  .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_addr(dir_addr),
  .cmo_done(cmo_done)
);

// File: tb/tb_coh_fwd_filter.sv
module tb_coh_fwd_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // entry: {cfg[1:0], op[2:0], dest[1:0]}; dest 0=forward, 1=directory, 2=local done
  localparam logic [6:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 2'd0}, {2'd0, 3'd1, 2'd0}, {2'd0, 3'd2, 2'd2}, {2'd0, 3'd3, 2'd2},
    {2'd0, 3'd4, 2'd1}, {2'd2, 3'd2, 2'd0}, {2'd2, 3'd3, 2'd0}, {2'd2, 3'd4, 2'd1},
    {2'd1, 3'd4, 2'd0}, {2'd1, 3'd2, 2'd2}, {2'd3, 3'd4, 2'd0}, {2'd3, 3'd3, 2'd0},
    {2'd3, 3'd5, 2'd0}, {2'd0, 3'd7, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_valid = 0, reg_write = 0, reg_secure = 0, reg_priv = 0;
  logic [63:0] reg_wdata = '0;
  logic reg_resp_valid, reg_err;
  logic [63:0] reg_rdata;
  logic req_valid = 0, req_ready;
  logic [2:0] req_op = '0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_data = '0;
  logic [3:0] req_src = '0;
  logic fwd_valid, fwd_ready = 1;
  logic [2:0] fwd_op;
  logic [31:0] fwd_addr;
  logic [63:0] fwd_data;
  logic [3:0] fwd_src;
  logic dir_valid, dir_ready = 1;
  logic [31:0] dir_addr;
  logic [3:0] dir_src;
  logic cmo_done;
  logic [3:0] cmo_done_src;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_fwd_filter dut (.*);

  task automatic check(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_access(input logic wr, input logic sec, input logic prv, input logic [63:0] wd,
                            output logic [63:0] rd, output logic er);
    @(negedge clk);
    reg_valid = 1; reg_write = wr; reg_secure = sec; reg_priv = prv; reg_wdata = wd;
    @(posedge clk); #1;
    check(reg_resp_valid === 1'b1, "R2 response strobe", {127'b0, reg_resp_valid}, 1);
    rd = reg_rdata; er = reg_err;
    @(negedge clk);
    reg_valid = 0;
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic [1:0] d);
    if (op == 3'd2 || op == 3'd3) return (d == 2'd2) ? "R4 maintenance stopped" : "R3 maintenance forwarded";
    if (op == 3'd4) return (d == 2'd1) ? "R6 evict to directory" : "R5 evict forwarded";
    return "R7 normal forwarded";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    logic er;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state
    check(!fwd_valid && !dir_valid && !cmo_done, "R1 idle outputs after reset",
          {fwd_valid, dir_valid, cmo_done}, 0);
    reg_access(0, 1, 1, '0, rd, er);
    check(rd == 64'd0 && !er, "R1 reset value", rd, 0);

    // R1: reserved bits ignore writes and read zero
    reg_access(1, 1, 1, '1, rd, er);
    check(!er, "R2 allowed write no error", er, 0);
    reg_access(0, 1, 1, '0, rd, er);
    check(rd == 64'd3, "R1 reserved bits read zero", rd, 3);

    // R2: refused accesses
    reg_access(1, 0, 1, '0, rd, er);
    check(er && rd == 0, "R2 non-secure write refused", {er, rd}, {1'b1, 64'd0});
    reg_access(1, 1, 0, '0, rd, er);
    check(er, "R2 non-privileged write refused", er, 1);
    reg_access(0, 1, 0, '0, rd, er);
    check(er && rd == 0, "R2 non-privileged read returns zero", {er, rd}, {1'b1, 64'd0});
    reg_access(0, 1, 1, '0, rd, er);
    check(rd == 64'd3, "R2 register unchanged by refused writes", rd, 3);

    // Table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] cfg, d;
      logic [2:0] op;
      logic ok;
      {cfg, op, d} = VEC[i];
      reg_access(1, 1, 1, {62'b0, cfg}, rd, er);
      @(negedge clk);
      req_valid = 1; req_op = op; req_addr = 32'h100 + 32'(i * 16);
      req_data = {32'hDA7A0000, 32'(i)}; req_src = 4'(i);
      #1;
      check(req_ready, tag_of(op, d), {127'b0, req_ready}, 1);
      @(posedge clk); #1;
      ok = (fwd_valid == (d == 0)) && (dir_valid == (d == 1)) && (cmo_done == (d == 2));
      if (d == 0) ok = ok && fwd_op == op && fwd_addr == req_addr && fwd_data == req_data && fwd_src == req_src;
      if (d == 1) ok = ok && dir_addr == req_addr && dir_src == req_src;
      if (d == 2) ok = ok && cmo_done_src == req_src;
      check(ok, tag_of(op, d), {fwd_valid, dir_valid, cmo_done}, {d == 0, d == 1, d == 2});
      @(negedge clk);
      req_valid = 0;
    end

    // R8: back-pressure on the forward port
    reg_access(1, 1, 1, 64'd0, rd, er);
    @(negedge clk);
    fwd_ready = 0;
    req_valid = 1; req_op = 3'd0; req_addr = 32'hA000; req_src = 4'd1;
    @(posedge clk); #1;
    check(fwd_valid && fwd_addr == 32'hA000, "R8 first request held", fwd_addr, 32'hA000);
    @(negedge clk);
    req_addr = 32'hB000; req_src = 4'd2;
    #1;
    check(!req_ready, "R8 ready low while stage full", req_ready, 0);
    @(posedge clk); #1;
    check(fwd_valid && fwd_addr == 32'hA000, "R8 payload stable under stall", fwd_addr, 32'hA000);
    @(negedge clk);
    fwd_ready = 1;
    #1;
    check(req_ready, "R8 ready while draining", req_ready, 1);
    @(posedge clk); #1;
    check(fwd_valid && fwd_addr == 32'hB000, "R8 second request follows", fwd_addr, 32'hB000);
    @(negedge clk);
    req_valid = 0;
    @(posedge clk);

    // R4: stopped maintenance passes while forward port is stalled
    @(negedge clk);
    fwd_ready = 0;
    req_valid = 1; req_op = 3'd1; req_addr = 32'hC000; req_src = 4'd3;
    @(posedge clk);
    @(negedge clk);
    req_op = 3'd3; req_addr = 32'hC040; req_src = 4'd9;
    #1;
    check(req_ready, "R4 stopped maintenance ignores stall", req_ready, 1);
    @(posedge clk); #1;
    check(cmo_done && cmo_done_src == 4'd9 && fwd_addr == 32'hC000,
          "R4 local completion during stall", {cmo_done, cmo_done_src}, {1'b1, 4'd9});
    @(negedge clk);
    req_valid = 0;
    @(posedge clk); #1;
    check(!cmo_done, "R4 completion is one cycle", cmo_done, 0);
    @(negedge clk);
    fwd_ready = 1;
    @(posedge clk);

    // R9: write and request at the same edge
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_secure = 1; reg_priv = 1; reg_wdata = 64'd2;
    req_valid = 1; req_op = 3'd2; req_addr = 32'hD000; req_src = 4'd5;
    @(posedge clk); #1;
    check(cmo_done && !fwd_valid, "R9 same-edge request uses old setting",
          {cmo_done, fwd_valid}, 2'b10);
    @(negedge clk);
    reg_valid = 0;
    req_addr = 32'hD040;
    @(posedge clk); #1;
    check(fwd_valid && fwd_op == 3'd2 && fwd_addr == 32'hD040 && !cmo_done,
          "R9 next request uses new setting", {fwd_valid, fwd_op}, {1'b1, 3'd2});
    @(negedge clk);
    req_valid = 0;
    @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule